// File: doc/BRIEF.md
# SPI Slave Serial Front End with Pause Control

This block is the pin-facing half of a serial memory slave. It runs on a fast system clock and oversamples four slow serial pins: an active-low select, the serial clock, the data input and an active-low pause line. Both idle-low and idle-high serial clock polarity work unchanged. In both, a bit is taken on the rising serial clock edge and the output moves on the falling edge. Received bits are collected most significant bit first. Each finished byte is handed to a downstream sequencer with a one-cycle strobe. Bytes that the sequencer supplies are shifted out most significant bit first. The block owns the output enable.

A pause (hold) line can freeze a transfer part way through a byte. While paused, serial clock edges and data are ignored and the output is released. The bit position survives, so the transfer carries on where it stopped. When select rises, the block emits a strobe that carries the exact number of bits received during that selection. The sequencer uses it to accept a write only if the count is a multiple of eight.

Top module: `spi_hold_front`

## Requirements
- R1: On each rising serial clock edge while selected and not paused, the data input is shifted in MSB first. After every eighth such edge, `rxStrobe` pulses for one cycle and `rxByte` holds the assembled byte. Any pin change reaches the outputs on the third system clock edge after it is applied.
- R2: On a falling serial clock edge while selected and not paused, the output register is loaded from `txData` if the received bit count is a multiple of 8, including zero; `txTake` pulses for that load. On any other such edge, the register shifts left by one. `misoOut` is always the register's MSB.
- R3: `misoOe` is high only while the block is selected, not paused, `txEnable` is high and the synchronized select pin is low. It drops in the same cycle that the select rise is seen.
- R4: After reset, no transfer is accepted until select is seen going from high to low. A select pin already held low through reset does not select the block.
- R5: A pause starts only when the pause pin falls while the block is selected and the synchronized serial clock is low.
- R6: A pause ends only when the pause pin rises while the serial clock is low. Pause pin edges that occur while the clock is high are ignored, whether or not the block is paused.
- R7: While paused, serial clock edges and the data input have no effect, the bit count is frozen and the output enable is low.
- R8: When select rises while selected, `deselStrobe` pulses for one cycle. It carries in `deselBits` the number of rising edges taken since the selection, and in `deselInHold` whether a pause was active. A new selection clears both the count and any pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csNPin | input | 1 | Serial select pin, active low, asynchronous |
| sckPin | input | 1 | Serial clock pin, asynchronous |
| mosiPin | input | 1 | Serial data input pin, asynchronous |
| holdNPin | input | 1 | Pause pin, active low, asynchronous |
| txData | input | DATA_W | Next byte to send, taken on `txTake` |
| txEnable | input | 1 | Sequencer request to drive the output |
| misoOut | output | 1 | Serial data output value |
| misoOe | output | 1 | Output enable for the serial data pad |
| rxByte | output | DATA_W | Last complete received byte |
| rxStrobe | output | 1 | One-cycle pulse when `rxByte` is new |
| txTake | output | 1 | One-cycle pulse when `txData` was loaded |
| deselStrobe | output | 1 | One-cycle pulse when select rose |
| deselBits | output | CNT_W | Bits received in the ended selection |
| deselInHold | output | 1 | Selection ended while paused |

## Verification
A miscounted bit position shows at the ports within one byte. `rxStrobe` fires on the wrong edge, `txTake` lands on the wrong falling edge, and `deselBits` disagrees at the next deselect. A pause flag stuck in the wrong state shows in the very cycle it diverges, because `misoOe` depends on it directly. Clock edges then stop counting or keep counting during the pause. A behavioural model advances in lockstep with the design, so every such divergence is flagged on the clock where it first reaches an output.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Index of each pin inside the synchronized pin vector
  localparam int PIN_CS    = 0;
  localparam int PIN_SCK   = 1;
  localparam int PIN_MOSI  = 2;
  localparam int PIN_HOLD  = 3;
  localparam int PIN_COUNT = 4;

  // Strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic startSel;   // a new selection begins
    logic endSel;     // the current selection ends
    logic sampleBit;  // take one bit on a serial clock rise
    logic shiftOut;   // advance the output on a serial clock fall
    logic heldNow;    // transfer is currently paused
  } ctrlStrb_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinSync
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= pinIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign pinSync = chain[STAGES-1];

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csS,
  input  logic      sckS,
  input  logic      holdS,
  input  logic      txEnable,
  output ctrlStrb_t strb,
  output logic      misoOe
);

  logic csPrev, sckPrev, holdPrev;
  logic selected, held;
  logic csRise, csFall, sckRise, sckFall, holdRise, holdFall;
  logic active;

  // Previous values start at the sync chain reset values, so no edge
  // appears until a pin really moves after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b0;
      sckPrev  <= 1'b0;
      holdPrev <= 1'b1;
    end else begin
      csPrev   <= csS;
      sckPrev  <= sckS;
      holdPrev <= holdS;
    end
  end

  assign csRise   =  csS   & ~csPrev;
  assign csFall   = ~csS   &  csPrev;
  assign sckRise  =  sckS  & ~sckPrev;
  assign sckFall  = ~sckS  &  sckPrev;
  assign holdRise =  holdS & ~holdPrev;
  assign holdFall = ~holdS &  holdPrev;

  assign active = selected & ~held & ~csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected <= 1'b0;
      held     <= 1'b0;
    end else if (selected && csRise) begin
      selected <= 1'b0;
      held     <= 1'b0;
    end else if (!selected && csFall) begin
      selected <= 1'b1;
      held     <= 1'b0;
    end else if (selected) begin
      if (!held && holdFall && !sckS)     held <= 1'b1;
      else if (held && holdRise && !sckS) held <= 1'b0;
    end
  end

  assign strb.startSel  = ~selected & csFall;
  assign strb.endSel    =  selected & csRise;
  assign strb.sampleBit =  active & sckRise;
  assign strb.shiftOut  =  active & sckFall;
  assign strb.heldNow   =  held;

  assign misoOe = active & txEnable;

  // R5: a pause can only begin from a selected state with the clock low
  p_enter_low_clk_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(held) |-> ($past(selected) && !$past(sckS)));

  // R6: leaving a pause inside a selection needs the clock low
  p_leave_low_clk_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(held) && selected) |-> !$past(sckS));

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] txData,
  output logic              misoOut,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxStrobe,
  output logic              txTake,
  output logic              deselStrobe,
  output logic [CNT_W-1:0]  deselBits,
  output logic              deselInHold
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic              lastBit;
  logic              onBoundary;

  assign lastBit    = (bitCnt[IDX_W-1:0] == {IDX_W{1'b1}});
  assign onBoundary = (bitCnt[IDX_W-1:0] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt      <= '0;
      rxShift     <= '0;
      rxByte      <= '0;
      rxStrobe    <= 1'b0;
      txShift     <= '0;
      txTake      <= 1'b0;
      deselStrobe <= 1'b0;
      deselBits   <= '0;
      deselInHold <= 1'b0;
    end else begin
      rxStrobe    <= 1'b0;
      txTake      <= 1'b0;
      deselStrobe <= 1'b0;

      if (strb.startSel) bitCnt <= '0;

      if (strb.sampleBit) begin
        rxShift <= {rxShift[DATA_W-2:0], mosiS};
        bitCnt  <= bitCnt + 1'b1;
        if (lastBit) begin
          rxStrobe <= 1'b1;
          rxByte   <= {rxShift[DATA_W-2:0], mosiS};
        end
      end

      if (strb.shiftOut) begin
        if (onBoundary) begin
          txShift <= txData;
          txTake  <= 1'b1;
        end else begin
          txShift <= {txShift[DATA_W-2:0], 1'b0};
        end
      end

      if (strb.endSel) begin
        deselStrobe <= 1'b1;
        deselBits   <= bitCnt;
        deselInHold <= strb.heldNow;
      end
    end
  end

  assign misoOut = txShift[DATA_W-1];

  // R1: a byte strobe always leaves the count on a byte boundary
  p_byte_boundary_r1: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |-> (bitCnt[IDX_W-1:0] == '0));

  // R7: a paused cycle never moves the count
  p_count_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.heldNow |=> $stable(bitCnt));

  // R8: the deselect report is a single-cycle pulse
  p_desel_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    deselStrobe |=> !deselStrobe);

  // R2: a load pulse only follows a boundary-aligned count
  p_take_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> (bitCnt[IDX_W-1:0] == '0));

endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csNPin,
  input  logic              sckPin,
  input  logic              mosiPin,
  input  logic              holdNPin,
  input  logic [DATA_W-1:0] txData,
  input  logic              txEnable,
  output logic              misoOut,
  output logic              misoOe,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxStrobe,
  output logic              txTake,
  output logic              deselStrobe,
  output logic [CNT_W-1:0]  deselBits,
  output logic              deselInHold
);

  // Select resets to "low" so a pin low through reset never looks like a fall.
  localparam logic [PIN_COUNT-1:0] SYNC_RST = PIN_COUNT'(1) << PIN_HOLD;

  logic [PIN_COUNT-1:0] pinRaw, pinS;
  ctrlStrb_t            strb;

  always_comb begin
    pinRaw           = '0;
    pinRaw[PIN_CS]   = csNPin;
    pinRaw[PIN_SCK]  = sckPin;
    pinRaw[PIN_MOSI] = mosiPin;
    pinRaw[PIN_HOLD] = holdNPin;
  end

  spi_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .pinIn(pinRaw), .pinSync(pinS)
  );

  spi_hold_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .csS(pinS[PIN_CS]), .sckS(pinS[PIN_SCK]), .holdS(pinS[PIN_HOLD]),
    .txEnable(txEnable), .strb(strb), .misoOe(misoOe)
  );

  spi_shift_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(pinS[PIN_MOSI]),
    .txData(txData), .misoOut(misoOut), .rxByte(rxByte), .rxStrobe(rxStrobe),
    .txTake(txTake), .deselStrobe(deselStrobe), .deselBits(deselBits),
    .deselInHold(deselInHold)
  );

endmodule

// File: tb/spi_hold_front_tb.sv
module spi_hold_front_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;   // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csNPin = 1'b1, sckPin = 1'b0, mosiPin = 1'b0, holdNPin = 1'b1;
  logic [7:0]  txData = 8'h00;
  logic        txEnable = 1'b0;
  logic        misoOut, misoOe, rxStrobe, txTake, deselStrobe, deselInHold;
  logic [7:0]  rxByte;
  logic [15:0] deselBits;

  int total = 0, bad = 0;
  bit finished = 0;

  spi_hold_front u_dut (
    .clk(clk), .rstN(rstN), .csNPin(csNPin), .sckPin(sckPin), .mosiPin(mosiPin),
    .holdNPin(holdNPin), .txData(txData), .txEnable(txEnable), .misoOut(misoOut),
    .misoOe(misoOe), .rxByte(rxByte), .rxStrobe(rxStrobe), .txTake(txTake),
    .deselStrobe(deselStrobe), .deselBits(deselBits), .deselInHold(deselInHold)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // pin vectors ordered {hold, mosi, sck, cs}
  logic [3:0] mS1, mS2, mP;
  bit         mSel, mHeld;
  int         mCnt;
  logic [7:0] mRx, mRxByte, mTx;
  bit         mRxStb, mTake, mDesel, mDeselHeld;
  int         mDeselBits;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 4'b1000; mS2 = 4'b1000; mP = 4'b1000;
      mSel = 0; mHeld = 0; mCnt = 0; mRx = 0; mRxByte = 0; mTx = 0;
      mRxStb = 0; mTake = 0; mDesel = 0; mDeselHeld = 0; mDeselBits = 0;
    end else begin
      bit csR, csF, skR, skF, hR, hF, wasHeld, act;
      csR = mS2[0] && !mP[0];  csF = !mS2[0] && mP[0];
      skR = mS2[1] && !mP[1];  skF = !mS2[1] && mP[1];
      hR  = mS2[3] && !mP[3];  hF  = !mS2[3] && mP[3];
      mRxStb = 0; mTake = 0; mDesel = 0;
      wasHeld = mHeld;
      if (mSel && csR) begin
        mDesel = 1; mDeselBits = mCnt; mDeselHeld = mHeld; mSel = 0; mHeld = 0;
      end else if (!mSel && csF) begin
        mSel = 1; mHeld = 0; mCnt = 0;
      end else if (mSel) begin
        act = !wasHeld && !mS2[0];
        if (act && skR) begin
          mRx = {mRx[6:0], mS2[2]};
          mCnt = (mCnt + 1) % 65536;
          if (mCnt % 8 == 0) begin mRxStb = 1; mRxByte = mRx; end
        end
        if (act && skF) begin
          if (mCnt % 8 == 0) begin mTx = txData; mTake = 1; end
          else mTx = {mTx[6:0], 1'b0};
        end
        if (!wasHeld && hF && !mS2[1]) mHeld = 1;
        else if (wasHeld && hR && !mS2[1]) mHeld = 0;
      end
      mP = mS2; mS2 = mS1; mS1 = {holdNPin, mosiPin, sckPin, csNPin};
    end
  end

  // Lockstep comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit expOe;
      expOe = mSel && !mHeld && txEnable && !mS2[0];
      check("R3", "misoOe", misoOe, expOe);
      if (expOe) check("R2", "misoOut", misoOut, mTx[7]);
      check("R2", "txTake", txTake, mTake);
      check("R1", "rxStrobe", rxStrobe, mRxStb);
      check("R1", "rxByte", rxByte, mRxByte);
      check("R8", "deselStrobe", deselStrobe, mDesel);
      check("R8", "deselBits", deselBits, mDeselBits);
      check("R8", "deselInHold", deselInHold, mDeselHeld);
    end
  end

  // ---------------- directed observation ----------------
  logic [7:0] rxQ[$];
  int deselSeen = 0, lastBits = 0, lastHeld = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rxStrobe) rxQ.push_back(rxByte);
      if (deselStrobe) begin deselSeen++; lastBits = deselBits; lastHeld = deselInHold; end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic spiBit(input logic b, output logic q);
    sckPin = 1'b0; mosiPin = b; waitClk(HALF);
    q = misoOut;
    sckPin = 1'b1; waitClk(HALF);
  endtask

  task automatic spiByte(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      logic qb;
      spiBit(d[i], qb);
      q[i] = qb;
    end
  endtask

  task automatic selectDev();
    csNPin = 1'b0; waitClk(HALF);
  endtask

  task automatic deselectDev(input bit idleHigh);
    if (!idleHigh) begin sckPin = 1'b0; waitClk(HALF); end
    csNPin = 1'b1; waitClk(6);
  endtask

  task automatic expectRx(input string req, input logic [7:0] exp);
    if (rxQ.size() == 0) check(req, "rx byte present", 0, 1);
    else check(req, "rx byte", rxQ.pop_front(), exp);
  endtask

  initial begin
    int sb;
    logic [7:0] q;
    logic qb;
    // Scenario: select already low through reset (R4)
    csNPin = 1'b0;
    repeat (4) @(posedge clk);
    #(CLK_PERIOD/4) rstN = 1'b1;
    waitClk(2);
    check("R3", "reset misoOe", misoOe, 0);
    check("R1", "reset rxStrobe", rxStrobe, 0);
    check("R8", "reset deselBits", deselBits, 0);
    txEnable = 1'b1;
    spiByte(8'hFF, q);
    sckPin = 1'b0; waitClk(HALF);
    check("R4", "no oe without select fall", misoOe, 0);
    csNPin = 1'b1; waitClk(6);
    check("R4", "no bytes before select fall", rxQ.size(), 0);
    check("R4", "no deselect before select fall", deselSeen, 0);

    // Idle-low clock: two bytes, second byte returns txData (R1, R2, R8)
    txData = 8'h96;
    selectDev();
    spiByte(8'hA5, q);
    spiByte(8'h3C, q);
    check("R2", "second byte out, idle-low", q, 8'h96);
    deselectDev(0);
    expectRx("R1", 8'hA5);
    expectRx("R1", 8'h3C);
    check("R8", "count after 2 bytes", lastBits, 16);
    check("R3", "oe low after deselect", misoOe, 0);

    // Idle-high clock (R1, R2)
    txData = 8'h4E;
    sckPin = 1'b1; waitClk(HALF);
    selectDev();
    spiByte(8'h5A, q);
    check("R2", "first byte out, idle-high", q, 8'h4E);
    deselectDev(1);
    expectRx("R1", 8'h5A);
    check("R8", "count idle-high", lastBits, 8);
    sckPin = 1'b0; waitClk(HALF);

    // Partial transfer (R8)
    selectDev();
    spiByte(8'h12, q);
    for (int i = 0; i < 3; i++) spiBit(1'b1, qb);
    deselectDev(0);
    expectRx("R1", 8'h12);
    check("R8", "count on partial byte", lastBits, 11);

    // Pause mid-byte with clock wiggles (R5, R7)
    selectDev();
    for (int i = 7; i >= 3; i--) spiBit(sb[0] ^ 1'b0 ^ ((8'hC3 >> i) & 1), qb);
    sckPin = 1'b0; waitClk(HALF);
    holdNPin = 1'b0; waitClk(HALF);
    check("R5", "paused oe low", misoOe, 0);
    for (int i = 0; i < 3; i++) begin
      mosiPin = 1'b0; sckPin = 1'b1; waitClk(HALF); sckPin = 1'b0; waitClk(HALF);
    end
    check("R7", "no byte during pause", rxQ.size(), 0);
    holdNPin = 1'b1; waitClk(HALF);
    check("R7", "oe back after pause", misoOe, 1);
    for (int i = 2; i >= 0; i--) spiBit((8'hC3 >> i) & 1, qb);
    spiByte(8'h81, q);
    deselectDev(0);
    expectRx("R7", 8'hC3);
    expectRx("R7", 8'h81);
    check("R7", "count across pause", lastBits, 16);
    check("R8", "not paused at end", lastHeld, 0);

    // Pause pin falls while clock high: ignored (R6)
    selectDev();
    spiBit(1'b0, qb); spiBit(1'b1, qb);
    holdNPin = 1'b0; waitClk(HALF);
    sckPin = 1'b0; waitClk(HALF);
    check("R6", "fall with clock high ignored", misoOe, 1);
    holdNPin = 1'b1; waitClk(HALF);
    for (int i = 5; i >= 0; i--) spiBit((8'h6B >> i) & 1, qb);
    deselectDev(0);
    expectRx("R6", 8'h6B);
    check("R6", "count with ignored pause", lastBits, 8);

    // Pause release while clock high: ignored (R6)
    selectDev();
    for (int i = 7; i >= 5; i--) spiBit((8'hD4 >> i) & 1, qb);
    sckPin = 1'b0; waitClk(HALF);
    holdNPin = 1'b0; waitClk(HALF);
    sckPin = 1'b1; waitClk(HALF);
    holdNPin = 1'b1; waitClk(HALF);
    sckPin = 1'b0; waitClk(HALF);
    check("R6", "release with clock high ignored", misoOe, 0);
    holdNPin = 1'b0; waitClk(HALF);
    holdNPin = 1'b1; waitClk(HALF);
    check("R6", "release with clock low", misoOe, 1);
    for (int i = 4; i >= 0; i--) spiBit((8'hD4 >> i) & 1, qb);
    deselectDev(0);
    expectRx("R6", 8'hD4);
    check("R6", "count after late release", lastBits, 8);

    // Deselect while paused, then fresh selection (R8)
    selectDev();
    for (int i = 0; i < 4; i++) spiBit(1'b1, qb);
    sckPin = 1'b0; waitClk(HALF);
    holdNPin = 1'b0; waitClk(HALF);
    csNPin = 1'b1; waitClk(6);
    check("R8", "count when aborted", lastBits, 4);
    check("R8", "abort flagged as paused", lastHeld, 1);
    selectDev();
    check("R8", "new selection not paused", misoOe, 1);
    spiByte(8'h27, q);
    deselectDev(0);
    holdNPin = 1'b1; waitClk(4);
    expectRx("R8", 8'h27);
    check("R8", "count after reselect", lastBits, 8);
    check("R8", "reselect not paused", lastHeld, 0);

    waitClk(4);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial sb = 0;
  int sb;

endmodule